// File: doc/BRIEF.md
# Multi-UART host register front-end

This block sits between a 32-bit memory-mapped host window and a bank of 16550-style UART channels. It decodes each host access. An access to the low region reaches a small global register file. That file holds a constant identification word, the channel count, a live interrupt status vector, and two enable masks: one for interrupts and one for wake. Each mask is changed through a pair of write-one-to-set and write-one-to-clear registers.

An access to a higher offset is routed to one channel's register port. Each channel window has a fixed base and a fixed stride. The upper half of each window is a silent area reserved for DMA. A window whose index lies at or past the configured channel count reads as zero.

The per-channel interrupt requests are registered into the status vector. The status is then masked by the interrupt enables and reduced to a single level-sensitive interrupt line. Every host read returns its data exactly one cycle after the access is presented. Writes complete in the cycle they are presented.

Top module: `uart_bank_regif`

## Requirements
- R1: A read of offset 0x00 returns 0x00070002. A read of offset 0x04 returns NUM_CH. Writes to 0x00, 0x04 and 0x08 change no register.
- R2: A read of offset 0x08 returns the status vector. Bit i equals the value `ch_irq_i[i]` had at the previous rising clock edge. Bits at and above NUM_CH read 0.
- R3: A write to offset 0x0C ORs `wdata_i[NUM_CH-1:0]` into the interrupt enable mask. A read of 0x0C returns the mask, zero-extended to 32 bits.
- R4: A write to offset 0x10 clears each enable bit written as 1. A read of 0x10 returns the bitwise inverse of the zero-extended mask, so bits at and above NUM_CH read 1.
- R5: Offsets 0x14 (set) and 0x18 (clear, inverted read) act the same way on a separate wake mask. The wake mask never affects `irq_o`.
- R6: `irq_o` is high exactly when (status AND interrupt enable) is nonzero. It reflects a change of `ch_irq_i`, or an enable write, from the next rising edge on.
- R7: A read of any other offset below 0x1000 returns 0, and a write there is ignored.
- R8: At offsets from 0x1000 upward, the channel index is (offset-0x1000)/0x200 and the register select `ch_sel_o` is `addr_i[2:0]`. A hit drives `ch_wdata_o` = `wdata_i[7:0]`. It also raises a strobe in the access cycle on the selected channel only: `ch_wr_o[idx]` for a write, `ch_rd_o[idx]` for a read.
- R9: Within a channel window, offsets whose remainder is 0x100 or more form the DMA area. Reads there return 0, writes there raise no strobe, and no channel register changes.
- R10: A channel index at or beyond NUM_CH (1 to 16) reads as 0 and raises no strobe.
- R11: A read presented with `req_i` in one cycle sets `rvalid_o` and `rdata_o` in the next cycle. For a channel hit, `rdata_o` holds the zero-extended byte on `ch_rdata_i` for that channel in the access cycle.
- R12: Reset (active-low `rst_ni`) clears the status, interrupt enable and wake masks, `irq_o`, `rvalid_o` and `rdata_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host access valid this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset inside the window |
| wdata_i | input | 32 | Host write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read |
| rvalid_o | output | 1 | Read data valid |
| irq_o | output | 1 | Combined level interrupt |
| ch_wr_o | output | NUM_CH | Per-channel write strobe |
| ch_rd_o | output | NUM_CH | Per-channel read strobe |
| ch_sel_o | output | SEL_W | Channel register select |
| ch_wdata_o | output | CH_DW | Channel write byte |
| ch_rdata_i | input | NUM_CH*CH_DW | Per-channel read bytes, channel i at bits [i*CH_DW +: CH_DW] |
| ch_irq_i | input | NUM_CH | Per-channel interrupt requests |

## Verification
The results fall due at three different times:

- Channel strobes, select and write byte are combinational. The bench samples them shortly after driving an access and before the clock edge.
- Read data and `rvalid_o` are sampled at the falling edge after the accepting rising edge.
- `irq_o` is checked at that same falling edge. Its expected value uses the request vector driven before the edge and the enables after that edge's write.

A status read returns the request vector latched one edge earlier, so the bench predicts it from the vector of the previous access step. Channel registers are modelled in the bench and updated only by observed strobes. A stray strobe, or one that is missing, therefore shows up in a later readback.

// File: rtl/uart_bank_pkg.sv
package uart_bank_pkg;
  localparam logic [31:0] ID_WORD    = 32'h0007_0002;
  localparam int unsigned CH_BASE    = 32'h1000;
  localparam int unsigned STRIDE_LOG = 9;
  localparam int unsigned DMA_BIT    = 8;

  localparam logic [11:0] OFF_ID    = 12'h000;
  localparam logic [11:0] OFF_CNT   = 12'h004;
  localparam logic [11:0] OFF_STAT  = 12'h008;
  localparam logic [11:0] OFF_ENSET = 12'h00C;
  localparam logic [11:0] OFF_ENCLR = 12'h010;
  localparam logic [11:0] OFF_WKSET = 12'h014;
  localparam logic [11:0] OFF_WKCLR = 12'h018;

  typedef enum logic [1:0] {
    ACC_NONE,
    ACC_GLOB,
    ACC_CHAN,
    ACC_VOID
  } acc_e;
endpackage

// File: rtl/uart_bank_decode.sv
module uart_bank_decode
  import uart_bank_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned ADDR_W = 14,
  parameter int unsigned SEL_W  = 3,
  localparam int unsigned IDX_W = ADDR_W - STRIDE_LOG
) (
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  output acc_e              acc_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [SEL_W-1:0]  sel_o
);
  localparam logic [ADDR_W-1:0] BASE_L   = ADDR_W'(CH_BASE);
  localparam logic [IDX_W-1:0]  BASE_IDX = IDX_W'(CH_BASE >> STRIDE_LOG);
  localparam logic [IDX_W:0]    CNT_L    = (IDX_W+1)'(NUM_CH);

  logic in_chan;
  logic in_dma;

  assign in_chan = (addr_i >= BASE_L);
  assign in_dma  = addr_i[DMA_BIT];
  assign idx_o   = addr_i[ADDR_W-1:STRIDE_LOG] - BASE_IDX;
  assign sel_o   = addr_i[SEL_W-1:0];

  always_comb begin
    acc_o = ACC_NONE;
    if (req_i) begin
      if (!in_chan)                       acc_o = ACC_GLOB;
      else if (in_dma)                    acc_o = ACC_VOID;
      else if ({1'b0, idx_o} >= CNT_L)    acc_o = ACC_VOID;
      else                                acc_o = ACC_CHAN;
    end
  end
endmodule

// File: rtl/uart_bank_glob.sv
module uart_bank_glob
  import uart_bank_pkg::*;
#(
  parameter int unsigned NUM_CH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [11:0]       off_i,
  input  logic [NUM_CH-1:0] wbits_i,
  input  logic [NUM_CH-1:0] ch_irq_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o
);
  logic [NUM_CH-1:0] stat_q, en_q, wk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      en_q   <= '0;
      wk_q   <= '0;
    end else begin
      stat_q <= ch_irq_i;
      if (wr_i) begin
        unique case (off_i)
          OFF_ENSET: en_q <= en_q | wbits_i;
          OFF_ENCLR: en_q <= en_q & ~wbits_i;
          OFF_WKSET: wk_q <= wk_q | wbits_i;
          OFF_WKCLR: wk_q <= wk_q & ~wbits_i;
          default: ;
        endcase
      end
    end
  end

  assign irq_o = |(stat_q & en_q);

  always_comb begin
    unique case (off_i)
      OFF_ID:    rdata_o = ID_WORD;
      OFF_CNT:   rdata_o = 32'(NUM_CH);
      OFF_STAT:  rdata_o = 32'(stat_q);
      OFF_ENSET: rdata_o = 32'(en_q);
      OFF_ENCLR: rdata_o = ~32'(en_q);
      OFF_WKSET: rdata_o = 32'(wk_q);
      OFF_WKCLR: rdata_o = ~32'(wk_q);
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/uart_bank_chport.sv
module uart_bank_chport #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned CH_DW  = 8
) (
  input  logic                    hit_i,
  input  logic                    we_i,
  input  logic [IDX_W-1:0]        idx_i,
  input  logic [NUM_CH*CH_DW-1:0] ch_rdata_i,
  output logic [NUM_CH-1:0]       ch_wr_o,
  output logic [NUM_CH-1:0]       ch_rd_o,
  output logic [CH_DW-1:0]        rbyte_o
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_strb
    logic sel;
    assign sel        = hit_i && (idx_i == IDX_W'(i));
    assign ch_wr_o[i] = sel && we_i;
    assign ch_rd_o[i] = sel && !we_i;
  end

  always_comb begin
    rbyte_o = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (idx_i == IDX_W'(i)) rbyte_o = ch_rdata_i[i*CH_DW +: CH_DW];
    end
  end
endmodule

// File: rtl/uart_bank_regif.sv
module uart_bank_regif
  import uart_bank_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned ADDR_W = 14,
  parameter int unsigned CH_DW  = 8,
  parameter int unsigned SEL_W  = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_i,
  input  logic                    we_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [31:0]             wdata_i,
  output logic [31:0]             rdata_o,
  output logic                    rvalid_o,
  output logic                    irq_o,
  output logic [NUM_CH-1:0]       ch_wr_o,
  output logic [NUM_CH-1:0]       ch_rd_o,
  output logic [SEL_W-1:0]        ch_sel_o,
  output logic [CH_DW-1:0]        ch_wdata_o,
  input  logic [NUM_CH*CH_DW-1:0] ch_rdata_i,
  input  logic [NUM_CH-1:0]       ch_irq_i
);
  localparam int unsigned IDX_W = ADDR_W - STRIDE_LOG;

  acc_e             acc;
  logic [IDX_W-1:0] idx;
  logic [31:0]      glob_rd;
  logic [CH_DW-1:0] rbyte;
  logic [31:0]      rdata_q;
  logic             rvalid_q;
  logic             unused_wdata;

  assign unused_wdata = ^wdata_i;
  assign ch_wdata_o   = wdata_i[CH_DW-1:0];

  uart_bank_decode #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .SEL_W(SEL_W)
  ) u_dec (
    .req_i (req_i),
    .addr_i(addr_i),
    .acc_o (acc),
    .idx_o (idx),
    .sel_o (ch_sel_o)
  );

  uart_bank_glob #(.NUM_CH(NUM_CH)) u_glob (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    ((acc == ACC_GLOB) && we_i),
    .off_i   (addr_i[11:0]),
    .wbits_i (wdata_i[NUM_CH-1:0]),
    .ch_irq_i(ch_irq_i),
    .rdata_o (glob_rd),
    .irq_o   (irq_o)
  );

  uart_bank_chport #(
    .NUM_CH(NUM_CH), .IDX_W(IDX_W), .CH_DW(CH_DW)
  ) u_chp (
    .hit_i     (acc == ACC_CHAN),
    .we_i      (we_i),
    .idx_i     (idx),
    .ch_rdata_i(ch_rdata_i),
    .ch_wr_o   (ch_wr_o),
    .ch_rd_o   (ch_rd_o),
    .rbyte_o   (rbyte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= req_i && !we_i;
      if (req_i && !we_i) begin
        unique case (acc)
          ACC_GLOB: rdata_q <= glob_rd;
          ACC_CHAN: rdata_q <= 32'(rbyte);
          default:  rdata_q <= '0;
        endcase
      end
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
endmodule

// File: rtl/uart_bank_regif_chk.sv
module uart_bank_regif_chk #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned ADDR_W = 14
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rvalid_o,
  input logic              irq_o,
  input logic [NUM_CH-1:0] ch_wr_o,
  input logic [NUM_CH-1:0] ch_rd_o,
  input logic [NUM_CH-1:0] ch_irq_i
);
  localparam int unsigned IDX_W = ADDR_W - 9;
  localparam logic [ADDR_W-1:0] BASE_L = ADDR_W'(32'h1000);
  localparam logic [IDX_W:0]    CNT_L  = (IDX_W+1)'(NUM_CH);

  logic             zone;
  logic [IDX_W-1:0] cidx;
  logic             no_strb;

  assign zone    = addr_i >= BASE_L;
  assign cidx    = addr_i[ADDR_W-1:9] - IDX_W'(8);
  assign no_strb = (ch_wr_o == '0) && (ch_rd_o == '0);

  AST_WR_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ch_wr_o)); // R8
  AST_RD_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ch_rd_o)); // R8
  AST_WR_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ch_wr_o) |-> (req_i && we_i)); // R8
  AST_RD_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ch_rd_o) |-> (req_i && !we_i)); // R8
  AST_GLOB_NO_STRB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !zone) |-> no_strb); // R8
  AST_DMA_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && zone && addr_i[8]) |-> no_strb); // R9
  AST_BEYOND_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && zone && ({1'b0, cidx} >= CNT_L)) |-> no_strb); // R10
  AST_RVALID_DUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o); // R11
  AST_RVALID_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(req_i && !we_i)); // R11
  AST_IRQ_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ($past(ch_irq_i) != '0)); // R6
endmodule

bind uart_bank_regif uart_bank_regif_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .rvalid_o(rvalid_o),
  .irq_o   (irq_o),
  .ch_wr_o (ch_wr_o),
  .ch_rd_o (ch_rd_o),
  .ch_irq_i(ch_irq_i)
);

// File: tb/sim_uart_bank_regif.sv
module sim_uart_bank_regif;
  localparam int NCH = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [13:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        rvalid_o, irq_o;
  logic [NCH-1:0] ch_wr_o, ch_rd_o;
  logic [2:0]  ch_sel_o;
  logic [7:0]  ch_wdata_o;
  logic [NCH*8-1:0] ch_rdata_i;
  logic [NCH-1:0] ch_irq_i = '0;

  always #5 clk_i = ~clk_i;

  uart_bank_regif #(.NUM_CH(NCH)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o), .irq_o(irq_o),
    .ch_wr_o(ch_wr_o), .ch_rd_o(ch_rd_o), .ch_sel_o(ch_sel_o), .ch_wdata_o(ch_wdata_o),
    .ch_rdata_i(ch_rdata_i), .ch_irq_i(ch_irq_i)
  );

  // channel register model, changed only by observed strobes
  logic [7:0] chmem [NCH][8];
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NCH; i++) for (int j = 0; j < 8; j++) chmem[i][j] <= '0;
    end else begin
      for (int i = 0; i < NCH; i++) if (ch_wr_o[i]) chmem[i][ch_sel_o] <= ch_wdata_o;
    end
  end
  always_comb for (int i = 0; i < NCH; i++) ch_rdata_i[i*8 +: 8] = chmem[i][ch_sel_o];

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] emem [NCH][8];
  logic [NCH-1:0] en_m = '0, wk_m = '0, irqv = '0, prev = '0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [13:0] a);
    logic [13:0] rel;
    if (a < 14'h1000) begin
      case (a)
        14'h000, 14'h004: return "R1";
        14'h008: return "R2";
        14'h00C: return "R3";
        14'h010: return "R4";
        14'h014, 14'h018: return "R5";
        default: return "R7";
      endcase
    end
    rel = a - 14'h1000;
    if (rel[8]) return "R9";
    if (rel[13:9] >= NCH) return "R10";
    return "R11";
  endfunction

  // returns hit channel index or -1
  function automatic int chan_of(input logic [13:0] a);
    logic [13:0] rel;
    if (a < 14'h1000) return -1;
    rel = a - 14'h1000;
    if (rel[8] || rel[13:9] >= NCH) return -1;
    return int'(rel[13:9]);
  endfunction

  function automatic logic [31:0] exp_read(input logic [13:0] a);
    int c;
    if (a < 14'h1000) begin
      case (a)
        14'h000: return 32'h0007_0002;
        14'h004: return NCH;
        14'h008: return 32'(prev);
        14'h00C: return 32'(en_m);
        14'h010: return ~32'(en_m);
        14'h014: return 32'(wk_m);
        14'h018: return ~32'(wk_m);
        default: return 32'h0;
      endcase
    end
    c = chan_of(a);
    if (c < 0) return 32'h0;
    return 32'(emem[c][a[2:0]]);
  endfunction

  task automatic step(input logic we, input logic [13:0] a, input logic [31:0] wd,
                      input logic [NCH-1:0] nirq);
    logic [31:0] er;
    logic [NCH-1:0] es;
    int c;
    @(negedge clk_i);
    prev = irqv;
    irqv = nirq;
    ch_irq_i = nirq;
    req_i = 1'b1; we_i = we; addr_i = a; wdata_i = wd;
    er = exp_read(a);
    c = chan_of(a);
    es = (c >= 0) ? NCH'(1) << c : '0;
    #1;
    check(c >= 0 ? "R8" : tag_of(a), {ch_wr_o, ch_rd_o}, we ? {es, {NCH{1'b0}}} : {{NCH{1'b0}}, es});
    if (c >= 0) begin
      check("R8", {ch_sel_o, ch_wdata_o}, {a[2:0], wd[7:0]});
    end
    if (we) begin
      if (a == 14'h00C) en_m = en_m | wd[NCH-1:0];
      if (a == 14'h010) en_m = en_m & ~wd[NCH-1:0];
      if (a == 14'h014) wk_m = wk_m | wd[NCH-1:0];
      if (a == 14'h018) wk_m = wk_m & ~wd[NCH-1:0];
      if (c >= 0) emem[c][a[2:0]] = wd[7:0];
    end
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
    if (!we) begin
      check("R11", 32'(rvalid_o), 32'd1);
      check(tag_of(a), rdata_o, er);
    end
    check("R6", 32'(irq_o), 32'(|(irqv & en_m)));
  endtask

  initial begin
    for (int i = 0; i < NCH; i++) for (int j = 0; j < 8; j++) emem[i][j] = '0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    check("R12", {29'b0, irq_o, rvalid_o, |ch_wr_o}, 32'h0);
    check("R12", rdata_o, 32'h0);
    step(0, 14'h00C, 0, '0);
    step(0, 14'h014, 0, '0);
    step(0, 14'h010, 0, '0);
    step(0, 14'h008, 0, '0);
    // identification and count, read-only
    step(0, 14'h000, 0, '0);
    step(0, 14'h004, 0, '0);
    step(1, 14'h000, 32'hFFFF_FFFF, '0);
    step(1, 14'h004, 32'h1234_5678, '0);
    step(1, 14'h008, 32'hFFFF_FFFF, '0);
    step(0, 14'h000, 0, '0);
    step(0, 14'h004, 0, '0);
    step(0, 14'h00C, 0, '0);
    // undefined global offsets
    step(1, 14'h01C, 32'hFFFF_FFFF, '0);
    step(0, 14'h01C, 0, '0);
    step(0, 14'h800, 0, '0);
    step(0, 14'h002, 0, '0);
    // status tracks requests one edge later
    step(0, 14'h000, 0, 8'hA5);
    step(0, 14'h008, 0, 8'hA5);
    step(0, 14'h008, 0, 8'h00);
    // enable set/clear and level interrupt
    step(1, 14'h00C, 32'hFFFF_0008, 8'h08);
    step(0, 14'h00C, 0, 8'h08);
    step(0, 14'h010, 0, 8'h08);
    step(0, 14'h000, 0, 8'h00);
    step(0, 14'h000, 0, 8'h08);
    step(1, 14'h010, 32'h0000_0008, 8'h08);
    // wake mask has no effect on the line
    step(1, 14'h014, 32'hFFFF_FFFF, 8'hFF);
    step(0, 14'h014, 0, 8'hFF);
    step(0, 14'h018, 0, 8'hFF);
    step(1, 14'h018, 32'h0000_00F0, 8'hFF);
    step(0, 14'h018, 0, 8'hFF);
    step(0, 14'h00C, 0, 8'h00);
    // each channel: write then read
    for (int c = 0; c < NCH; c++) begin
      step(1, 14'(32'h1000 + c*32'h200 + c % 8), 32'hAB00 | c, '0);
      step(0, 14'(32'h1000 + c*32'h200 + c % 8), 0, '0);
    end
    // DMA area and beyond-count windows are silent
    step(1, 14'h1100, 32'hFF, '0);
    step(1, 14'h1107, 32'hFF, '0);
    step(0, 14'h1100, 0, '0);
    step(0, 14'h1000, 0, '0);
    step(0, 14'h1007, 0, '0);
    step(1, 14'h2000, 32'h5A, '0);
    step(1, 14'h3E07, 32'h5A, '0);
    step(0, 14'h2000, 0, '0);
    step(0, 14'h1000, 0, '0);
    step(0, 14'h1E07, 0, '0);
    // random mix
    for (int n = 0; n < 1500; n++) begin
      logic [13:0] a;
      logic [NCH-1:0] ni;
      int k;
      k = $urandom % 4;
      if (k == 0) begin
        case ($urandom % 9)
          0: a = 14'h000; 1: a = 14'h004; 2: a = 14'h008; 3: a = 14'h00C;
          4: a = 14'h010; 5: a = 14'h014; 6: a = 14'h018; 7: a = 14'h01C;
          default: a = 14'($urandom % 32'h1000);
        endcase
      end else begin
        a = 14'(32'h1000 + ($urandom % 24) * 32'h200 + ($urandom % 32'h200));
      end
      ni = (($urandom % 4) == 0) ? NCH'($urandom) : irqv;
      step(1'($urandom % 2), a, $urandom, ni);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule